// File: doc/BRIEF.md
# Serial Frequency Word Loader

This block takes a frequency control word for a sine synthesizer over a three-wire serial link and presents it to the phase accumulator. The link has a serial clock, a data line and a load control. Data bits are sampled on falling edges of the serial clock and fed into a shift register. The first bit sent becomes bit 0 of the word and the sixteenth becomes bit 15.

The shift register does not drive the synthesizer directly. A second register, the holding latch, supplies the active word. It copies the shift register only when the load control goes from low to high. Because of this, the running frequency never shows a partly shifted word.

All three serial lines come from another clock domain. Each one passes through a two-flop synchronizer before the block uses it, and edges are detected in the system clock domain. The system clock must be at least four times faster than the serial clock. Each copy into the latch is marked by a strobe that lasts one system clock.

Top module: `serial_word_loader`

## Requirements
- R1: While `rst_n` is low, and until the first load, `word_q` reads 0 and `word_upd` reads 0.
- R2: The shift register takes one bit per falling edge of `ser_clk`. A rising edge of `ser_clk`, or a high level held on it, shifts nothing.
- R3: Bits arrive least significant first. After the last 16 falling edges, the bit from the earliest of them is in `word_q[0]` and the bit from the latest is in `word_q[15]`. If more than 16 bits are sent, only the last 16 are kept.
- R4: Shifting alone never changes `word_q`. It changes only in the cycle where `word_upd` is high.
- R5: A low-to-high change on `ser_load` copies the shift register into `word_q`. In the same cycle `word_upd` is high for exactly one clock. Both take effect on the third rising edge of `clk` after the change on the pin.
- R6: Holding `ser_load` high does not cause another load and does not cause another strobe.
- R7: Bits shifted in while `ser_load` is high leave `word_q` unchanged. They are loaded at the next low-to-high change of `ser_load`.
- R8: A load does not clear the shift register. A second load with no new bits gives the same word again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its falling edge |
| ser_data | input | 1 | Serial data, least significant bit first |
| ser_load | input | 1 | Load control; its rising edge copies the word |
| word_q | output | WORD_W | Active frequency control word |
| word_upd | output | 1 | One-cycle strobe marking a new `word_q` |

## Verification
Each serial line passes through two synchronizer flops, and the load register follows them. As a result, `word_q` and `word_upd` change on the third rising edge of `clk` after a change on `ser_load`. The bench drives every input on a falling edge of `clk`. It then checks on the falling edges after the second and third rising edges, which confirms both that the strobe does not appear early and that it does appear when due. It checks again one edge later, and while the load control stays high, to confirm the strobe has ended. Each serial bit holds its clock level for four system cycles, so a falling edge always reaches the shift register well before the next load is sampled.

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [WORD_W-1:0] word_q,
  output logic              word_upd
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0]        sck_sync, sdat_sync, sld_sync;
  logic                sck_prev, sld_prev;
  logic                fall, load_rise;
  logic [WORD_W-1:0]   shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync  <= '0;
      sdat_sync <= '0;
      sld_sync  <= '0;
      sck_prev  <= 1'b0;
      sld_prev  <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[TOP-1:0], ser_clk};
      sdat_sync <= {sdat_sync[TOP-1:0], ser_data};
      sld_sync  <= {sld_sync[TOP-1:0], ser_load};
      sck_prev  <= sck_sync[TOP];
      sld_prev  <= sld_sync[TOP];
    end
  end

  assign fall      = sck_prev & ~sck_sync[TOP];
  assign load_rise = sld_sync[TOP] & ~sld_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shreg <= '0;
    else if (fall) shreg <= {sdat_sync[TOP], shreg[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_upd <= 1'b0;
    end else begin
      word_upd <= load_rise;
      if (load_rise) word_q <= shreg;
    end
  end

  p_shift_only_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(shreg));

  p_word_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_upd |-> word_q == $past(word_q));

  p_load_takes_shreg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_upd |-> word_q == $past(shreg));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_upd |=> !word_upd);

  p_strobe_needs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_upd) |-> $past(sld_sync[TOP]));
endmodule

// File: tb/serial_word_loader_bench.sv
module serial_word_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [W-1:0] word_q;
  logic word_upd;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_loader #(.WORD_W(W)) u_serial_word_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .word_q(word_q), .word_upd(word_upd));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_data = b; ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) send_bit(w[i]);
  endtask

  // raise ser_load, check strobe timing and value, then hold high (R5, R6)
  task automatic load_rise(input logic [W-1:0] exp, input string req);
    @(negedge clk); ser_load = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({req, " strobe not early"}, {31'd0, word_upd}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk({req, " strobe R5"}, {31'd0, word_upd}, 32'd1);
    chk({req, " word"}, {16'd0, word_q}, {16'd0, exp});
    @(negedge clk);
    chk({req, " strobe one cycle R5"}, {31'd0, word_upd}, 32'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (word_upd) chk("R6 no strobe while held", 32'd1, 32'd0);
    end
  endtask

  task automatic load_fall();
    @(negedge clk); ser_load = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset word", {16'd0, word_q}, 32'd0);
    chk("R1 reset strobe", {31'd0, word_upd}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 word after reset", {16'd0, word_q}, 32'd0);
  endtask

  task automatic t_basic();
    send_word(16'hA5C3);
    load_rise(16'hA5C3, "R3 basic");
    load_fall();
  endtask

  task automatic t_hold();
    send_word(16'h1234);
    chk("R4 shift leaves word", {16'd0, word_q}, 32'h0000A5C3);
    load_rise(16'h1234, "R4 later load");
    load_fall();
  endtask

  task automatic t_reload();
    load_rise(16'h1234, "R8 reload");
    load_fall();
  endtask

  task automatic t_rising_only();
    @(negedge clk); ser_data = 1'b1; ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    load_rise(16'h1234, "R2 rising edge no shift");
    load_fall();
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    load_rise(16'h891A, "R2 falling edge shifts");
    load_fall();
  endtask

  task automatic t_overlong();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_word(16'hBEEF);
    load_rise(16'hBEEF, "R3 last 16 kept");
    load_fall();
  endtask

  task automatic t_shift_while_high();
    load_rise(16'hBEEF, "R7 pre");
    send_word(16'h0F0F);
    chk("R7 word held while high", {16'd0, word_q}, 32'h0000BEEF);
    load_fall();
    load_rise(16'h0F0F, "R7 next rise");
    load_fall();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_reload();
    t_rising_only();
    t_overlong();
    t_shift_while_high();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule